// File: doc/BRIEF.md
# LUP Decomposition Engine with Partial Pivoting

This block factors a small square matrix of signed fixed-point values into a row permutation and packed lower, diagonal and upper factors. Software-side logic or a neighbouring engine loads the matrix element by element through a write port, pulses `start`, and waits for the one-cycle `done` pulse. It then reads the packed factors through a matrix read port and the pivot history through a separate permutation read port. The factors overwrite the matrix in place. Strictly below the diagonal sits L, whose unit diagonal is implied. Each diagonal position holds the reciprocal of that step's pivot. Strictly above the diagonal sits U, already scaled by the reciprocal of its row's pivot, and its unit diagonal is also implied.

Each elimination step works on column k and follows the same pattern. The engine scans rows k..N-1 for the largest magnitude in that column and physically swaps that row into position k. A sequential restoring divider forms the pivot reciprocal once. Every lower row is then scaled by that reciprocal to give its L entry, and the trailing part of the row is reduced by the L entry times the unscaled pivot row. Finally the pivot row itself is scaled. The problem shrinks by one order per step. If a column has no non-zero candidate, the engine stops, raises `singular` and writes an error code into the extra permutation entry.

The controller is a single state machine. IDLE goes to SEEK on `start`. SEEK advances one row per cycle and, after the last row, goes to FINISH if the best magnitude is zero, otherwise to SWAP. SWAP always goes to DIVIDE. DIVIDE waits for the reciprocal and then goes to UPDATE, or straight to NORM on the last step. UPDATE handles one lower row per cycle and goes to NORM after row N-1. NORM goes back to SEEK for the next column, or to FINISH after the last one. FINISH returns to IDLE.

Top module: `lup_engine`

## Requirements
- R1: After reset, every matrix element, every permutation entry, `singular` and `done` read 0.
- R2: While the engine is idle, a `wr_en` cycle stores `wr_data` at (`wr_row`, `wr_col`), and `rd_data` shows it combinationally at that address.
- R3: In step k the pivot is the row among k..N-1 with the largest absolute value in column k. On a tie the lowest row index wins. That row is exchanged with row k of the working array, and permutation entry k records the working-array index it came from.
- R4: The diagonal entry of step k holds the reciprocal r of the pivot p. Its magnitude is 2^(2F) divided by |p|, truncated and limited to 2^(DW-1)-1. Its sign is that of p. F is the number of fractional bits (8) and DW is the element width (16).
- R5: Every entry below the diagonal in column k becomes its value times r. A fixed-point product is the full signed product shifted right arithmetically by F bits and wrapped to DW bits.
- R6: For rows i>k and columns j>k, the entry becomes a[i][j] minus (L entry of row i) times a[k][j]. Here a[k][j] is the pivot row's value before scaling, and the difference wraps to DW bits.
- R7: After the trailing update, each entry of the pivot row right of the diagonal becomes its value times r.
- R8: After a complete factorisation, permutation entry N (the extra entry) reads 0.
- R9: If the largest magnitude in column k is zero, the engine stops without a swap. It raises `singular`, writes k+1 into permutation entry N and still pulses `done`.
- R10: `done` is high for exactly one cycle. With a start sampled at clock edge E, `done` is high in the cycle after edge E+L. A full run has L = N² + N·(2F+4), which is 96 at defaults. A step k that completes adds 2(N-k)+2F+3 to L, and a singular step k adds N-k.
- R11: `start` and `wr_en` have no effect while the engine is busy. The running factorisation and its latency are unchanged.
- R12: A start clears `singular` and all permutation entries, so entries for steps never reached read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a factorisation (idle only) |
| wr_en | input | 1 | Write one matrix element (idle only) |
| wr_row | input | AW | Write row index |
| wr_col | input | AW | Write column index |
| wr_data | input | DW | Element value, signed Q(DW-F).F |
| rd_row | input | AW | Read row index |
| rd_col | input | AW | Read column index |
| rd_data | output | DW | Element at the read address |
| perm_sel | input | PW | Permutation entry index, 0..N |
| perm_data | output | PW | Selected permutation entry |
| done | output | 1 | One-cycle completion pulse |
| singular | output | 1 | Zero pivot column found in last run |

## Verification
The latency L of each run is fixed by R10 and depends only on where the run stops. The bench derives the expected L from its own reference model and compares it with the number of edges counted between the start sample and the negative edge at which `done` is seen high. Reads of the matrix and permutation are due combinationally once `done` rises. The monitor therefore samples each address one time step after setting it, away from any edge. It checks `done` low again a full cycle later, and the busy-poke run must keep exactly the same L.

// File: rtl/lup_pkg.sv
package lup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_SWAP,
        ST_DIVIDE,
        ST_UPDATE,
        ST_NORM,
        ST_FINISH
    } lup_state_e;

endpackage

// File: rtl/lup_recip_div.sv
// Sequential restoring divider: forms 2^(2*FW) / |pivot| one quotient bit
// per cycle, saturates to the largest positive value, then restores the sign.
module lup_recip_div #(
    parameter int DW = 16,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] pivot,
    output logic          ready,
    output logic [DW-1:0] recip
);
    localparam int NW = 2 * FW + 1;
    localparam int CW = $clog2(NW + 1);
    localparam int XW = NW + DW;
    localparam logic [NW-1:0] ONE_SQ = NW'(1) << (2 * FW);
    localparam logic [DW-1:0] MAXP   = {1'b0, {(DW-1){1'b1}}};

    logic [DW-1:0] rem_q, dv_q, mag_in, rem_nx, qmag;
    logic [NW-1:0] num_q, quo_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, neg_q, fits;
    logic [DW:0]   trial;
    logic [XW-1:0] qx;

    assign mag_in = pivot[DW-1] ? DW'(-pivot) : pivot;
    assign trial  = {rem_q, num_q[NW-1]};
    assign fits   = (trial >= {1'b0, dv_q});
    assign rem_nx = fits ? DW'(trial - {1'b0, dv_q}) : trial[DW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            dv_q  <= '0;
            num_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            neg_q <= 1'b0;
            ready <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (go) begin
                rem_q <= '0;
                num_q <= ONE_SQ;
                quo_q <= '0;
                dv_q  <= mag_in;
                neg_q <= pivot[DW-1];
                cnt_q <= CW'(NW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_nx;
                num_q <= num_q << 1;
                quo_q <= {quo_q[NW-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    ready <= 1'b1;
                end
            end
        end
    end

    assign qx    = XW'(quo_q);
    assign qmag  = (qx > XW'(MAXP)) ? MAXP : qx[DW-1:0];
    assign recip = neg_q ? DW'(-qmag) : qmag;

endmodule

// File: rtl/lup_elim_row.sv
// One elimination row: forms the L entry of this row and reduces the
// trailing columns by L times the unscaled pivot row.
module lup_elim_row #(
    parameter int N  = 4,
    parameter int DW = 16,
    parameter int FW = 8,
    parameter int AW = 2
) (
    input  logic [AW-1:0]        col,
    input  logic [DW-1:0]        recip,
    input  logic [N-1:0][DW-1:0] row_i,
    input  logic [N-1:0][DW-1:0] row_p,
    output logic [N-1:0][DW-1:0] row_o
);
    function automatic logic [DW-1:0] fxmul(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic signed [2*DW-1:0] ax, bx, p;
        ax = {{DW{a[DW-1]}}, a};
        bx = {{DW{b[DW-1]}}, b};
        p  = ax * bx;
        return p[FW+DW-1:FW];
    endfunction

    logic [DW-1:0] lval;
    assign lval = fxmul(row_i[col], recip);

    for (genvar j = 0; j < N; j++) begin : g_lane
        assign row_o[j] = (AW'(j) < col)  ? row_i[j] :
                          (AW'(j) == col) ? lval :
                          DW'(row_i[j] - fxmul(lval, row_p[j]));
    end

endmodule

// File: rtl/lup_row_norm.sv
// Pivot-row finish: reciprocal onto the diagonal, entries to its right scaled.
module lup_row_norm #(
    parameter int N  = 4,
    parameter int DW = 16,
    parameter int FW = 8,
    parameter int AW = 2
) (
    input  logic [AW-1:0]        col,
    input  logic [DW-1:0]        recip,
    input  logic [N-1:0][DW-1:0] row_k,
    output logic [N-1:0][DW-1:0] row_o
);
    function automatic logic [DW-1:0] fxmul(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic signed [2*DW-1:0] ax, bx, p;
        ax = {{DW{a[DW-1]}}, a};
        bx = {{DW{b[DW-1]}}, b};
        p  = ax * bx;
        return p[FW+DW-1:FW];
    endfunction

    for (genvar j = 0; j < N; j++) begin : g_lane
        assign row_o[j] = (AW'(j) < col)  ? row_k[j] :
                          (AW'(j) == col) ? recip :
                          fxmul(row_k[j], recip);
    end

endmodule

// File: rtl/lup_engine.sv
module lup_engine #(
    parameter int N  = 4,
    parameter int DW = 16,
    parameter int FW = 8,
    parameter int AW = (N > 1) ? $clog2(N) : 1,
    parameter int PW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_row,
    input  logic [AW-1:0] wr_col,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_row,
    input  logic [AW-1:0] rd_col,
    output logic [DW-1:0] rd_data,
    input  logic [PW-1:0] perm_sel,
    output logic [PW-1:0] perm_data,
    output logic          done,
    output logic          singular
);
    import lup_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(N - 1);

    lup_state_e state, nstate;

    logic [N-1:0][DW-1:0] mat  [N];
    logic [PW-1:0]        perm [N+1];

    logic [AW-1:0] k, scan, row, best_row;
    logic [DW-1:0] best_mag, cur_elem, cur_mag, nxt_mag;
    logic          take, last_scan, last_k;

    logic          div_go, div_ready;
    logic [DW-1:0] divisor, recip;
    logic [N-1:0][DW-1:0] elim_out, norm_out;

    // pivot search datapath
    assign cur_elem  = mat[scan][k];
    assign cur_mag   = cur_elem[DW-1] ? DW'(-cur_elem) : cur_elem;
    assign take      = (scan == k) || (cur_mag > best_mag);
    assign nxt_mag   = take ? cur_mag : best_mag;
    assign last_scan = (scan == LAST);
    assign last_k    = (k == LAST);
    assign divisor   = mat[best_row][k];

    lup_recip_div #(.DW(DW), .FW(FW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .pivot (divisor),
        .ready (div_ready),
        .recip (recip)
    );

    lup_elim_row #(.N(N), .DW(DW), .FW(FW), .AW(AW)) u_elim (
        .col   (k),
        .recip (recip),
        .row_i (mat[row]),
        .row_p (mat[k]),
        .row_o (elim_out)
    );

    lup_row_norm #(.N(N), .DW(DW), .FW(FW), .AW(AW)) u_norm (
        .col   (k),
        .recip (recip),
        .row_k (mat[k]),
        .row_o (norm_out)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (start) nstate = ST_SEEK;
            ST_SEEK:   if (last_scan) nstate = (nxt_mag == '0) ? ST_FINISH : ST_SWAP;
            ST_SWAP:   nstate = ST_DIVIDE;
            ST_DIVIDE: if (div_ready) nstate = last_k ? ST_NORM : ST_UPDATE;
            ST_UPDATE: if (row == LAST) nstate = ST_NORM;
            ST_NORM:   nstate = last_k ? ST_FINISH : ST_SEEK;
            ST_FINISH: nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // state-decoded outputs
    always_comb begin
        done   = (state == ST_FINISH);
        div_go = (state == ST_SWAP);
    end

    // working array, counters and permutation record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) mat[r] <= '0;
            for (int p = 0; p <= N; p++) perm[p] <= '0;
            k        <= '0;
            scan     <= '0;
            row      <= '0;
            best_row <= '0;
            best_mag <= '0;
            singular <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        k        <= '0;
                        scan     <= '0;
                        singular <= 1'b0;
                        for (int p = 0; p <= N; p++) perm[p] <= '0;
                    end else if (wr_en) begin
                        mat[wr_row][wr_col] <= wr_data;
                    end
                end
                ST_SEEK: begin
                    if (take) begin
                        best_mag <= cur_mag;
                        best_row <= scan;
                    end
                    if (last_scan) begin
                        if (nxt_mag == '0) begin
                            singular <= 1'b1;
                            perm[N]  <= PW'(k) + PW'(1);
                        end
                    end else begin
                        scan <= scan + AW'(1);
                    end
                end
                ST_SWAP: begin
                    mat[k]        <= mat[best_row];
                    mat[best_row] <= mat[k];
                    perm[k]       <= PW'(best_row);
                end
                ST_DIVIDE: begin
                    if (div_ready) row <= k + AW'(1);
                end
                ST_UPDATE: begin
                    mat[row] <= elim_out;
                    row      <= row + AW'(1);
                end
                ST_NORM: begin
                    mat[k] <= norm_out;
                    if (!last_k) begin
                        k    <= k + AW'(1);
                        scan <= k + AW'(1);
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    assign rd_data   = mat[rd_row][rd_col];
    assign perm_data = (perm_sel <= PW'(N)) ? perm[perm_sel] : '0;

endmodule

// File: rtl/lup_engine_chk.sv
module lup_engine_chk #(
    parameter int DW = 16,
    parameter int AW = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic                singular,
    input lup_pkg::lup_state_e state,
    input logic [AW-1:0]       k,
    input logic [AW-1:0]       best_row,
    input logic                div_go,
    input logic [DW-1:0]       divisor,
    input logic                div_ready,
    input logic [DW-1:0]       recip
);
    import lup_pkg::*;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    singular_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(singular) |-> done);

    // R9
    nonzero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> (divisor != '0));

    // R3
    pivot_row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |-> (best_row >= k));

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE && state != ST_NORM) |=> $stable(k));

    // R4
    recip_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_ready |-> (recip != '0));

endmodule

bind lup_engine lup_engine_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .singular  (singular),
    .state     (state),
    .k         (k),
    .best_row  (best_row),
    .div_go    (div_go),
    .divisor   (divisor),
    .div_ready (div_ready),
    .recip     (recip)
);

// File: tb/lup_engine_test.sv
module lup_engine_test;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int FW = 8;
    localparam int AW = 2;
    localparam int PW = 3;
    localparam int NW = 2 * FW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_row = '0, wr_col = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_row = '0, rd_col = '0;
    logic [DW-1:0] rd_data;
    logic [PW-1:0] perm_sel = '0;
    logic [PW-1:0] perm_data;
    logic          done, singular;

    lup_engine #(.N(N), .DW(DW), .FW(FW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
        .perm_sel(perm_sel), .perm_data(perm_data),
        .done(done), .singular(singular)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    kind;   // 0 latency, 1 element, 2 perm entry, 3 singular, 4 done low
        int    a;
        int    b;
        int    val;
        string req;
    } item_t;

    item_t sb[$];
    int    checks = 0, errors = 0;
    int    flush_req = 0, served = 0;
    int    t_start = 0;
    bit    mon_busy = 1'b0;
    bit    finished = 1'b0;
    int    cur [N][N];
    int    seed = 7;

    task automatic report(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void push(int kind, int a, int b, int val, string req);
        item_t it;
        it.kind = kind; it.a = a; it.b = b; it.val = val; it.req = req;
        sb.push_back(it);
    endfunction

    // monitor: drains the scoreboard when a run completes or a flush is asked
    initial forever begin
        int lat, act;
        item_t it;
        @(negedge clk);
        if (done || flush_req != served) begin
            lat = cyc - t_start - 1;
            served = flush_req;
            mon_busy = 1'b1;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                act = 0;
                case (it.kind)
                    0: act = lat;
                    1: begin rd_row = AW'(it.a); rd_col = AW'(it.b); #1; act = int'($signed(rd_data)); end
                    2: begin perm_sel = PW'(it.a); #1; act = int'(perm_data); end
                    3: begin #1; act = int'(singular); end
                    default: begin @(negedge clk); #1; act = int'(done); end
                endcase
                report(act == it.val, it.req, $sformatf("kind%0d[%0d][%0d]", it.kind, it.a, it.b), act, it.val);
                @(negedge clk);
            end
            mon_busy = 1'b0;
        end
    end

    // reference arithmetic
    function automatic int w16(int x);
        logic signed [15:0] t;
        t = x[15:0];
        return int'(t);
    endfunction

    function automatic int fm(int x, int y);
        int p;
        p = x * y;
        return w16(p >>> FW);
    endfunction

    function automatic int rcp(int p);
        int m, q;
        m = (p < 0) ? -p : p;
        q = (1 << (2 * FW)) / m;
        if (q > 32767) q = 32767;
        return (p < 0) ? -q : q;
    endfunction

    task automatic model_push(input bit poke);
        int a [N][N];
        int pm [N+1];
        int lat, sing, best, bm, r, l, t;
        string tg;
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) a[i][j] = cur[i][j];
        for (int i = 0; i <= N; i++) pm[i] = 0;
        lat = 0; sing = 0;
        for (int k = 0; k < N; k++) begin
            best = k;
            bm = (a[k][k] < 0) ? -a[k][k] : a[k][k];
            for (int i = k + 1; i < N; i++) begin
                t = (a[i][k] < 0) ? -a[i][k] : a[i][k];
                if (t > bm) begin bm = t; best = i; end
            end
            if (bm == 0) begin
                sing = 1; pm[N] = k + 1; lat += N - k;
                break;
            end
            lat += 2 * (N - k) + NW + 2;
            for (int j = 0; j < N; j++) begin
                t = a[k][j]; a[k][j] = a[best][j]; a[best][j] = t;
            end
            pm[k] = best;
            r = rcp(a[k][k]);
            for (int i = k + 1; i < N; i++) begin
                l = fm(a[i][k], r);
                for (int j = k + 1; j < N; j++) a[i][j] = w16(a[i][j] - fm(l, a[k][j]));
                a[i][k] = l;
            end
            a[k][k] = r;
            for (int j = k + 1; j < N; j++) a[k][j] = fm(a[k][j], r);
        end
        push(0, 0, 0, lat, poke ? "R11" : "R10");
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin
            if (i == j)                tg = "R4";
            else if (j == 0)           tg = "R5";
            else if (i == 0)           tg = "R7";
            else                       tg = "R6";
            push(1, i, j, a[i][j], tg);
        end
        for (int i = 0; i < N; i++) push(2, i, 0, pm[i], sing ? "R12" : "R3");
        push(2, N, 0, pm[N], sing ? "R9" : "R8");
        push(3, 0, 0, sing, sing ? "R9" : "R12");
        push(4, 0, 0, 0, "R10");
    endtask

    task automatic load_cur();
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_row = AW'(i); wr_col = AW'(j); wr_data = cur[i][j][15:0];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        wait (sb.size() == 0 && !mon_busy);
        @(negedge clk);
    endtask

    task automatic flush();
        flush_req++;
        drain();
    endtask

    task automatic run_case(input bit poke);
        load_cur();
        model_push(poke);
        @(negedge clk);
        start = 1'b1;
        t_start = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1; wr_en = 1'b1; wr_row = '0; wr_col = '0; wr_data = 16'h1234;
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
        end
        drain();
    endtask

    task automatic set_row(int r, int a0, int a1, int a2, int a3);
        cur[r][0] = a0; cur[r][1] = a1; cur[r][2] = a2; cur[r][3] = a3;
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 2047) - 1024;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) push(1, i, j, 0, "R1");
        for (int i = 0; i <= N; i++) push(2, i, 0, 0, "R1");
        push(3, 0, 0, 0, "R1");
        push(4, 0, 0, 0, "R1");
        flush();

        // R2: load and read back before starting
        set_row(0, 0, 256, 512, 0);
        set_row(1, 768, 0, 256, 256);
        set_row(2, 256, 512, 0, 768);
        set_row(3, -512, 256, 256, 0);
        load_cur();
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) push(1, i, j, cur[i][j], "R2");
        flush();

        // pivoting needed in the first column (R3, R5, R6, R7)
        run_case(1'b0);

        // scaled identity
        set_row(0, 512, 0, 0, 0);
        set_row(1, 0, 512, 0, 0);
        set_row(2, 0, 0, 512, 0);
        set_row(3, 0, 0, 0, 512);
        run_case(1'b0);

        // tie on magnitude: lowest row wins (R3)
        set_row(0, 256, 128, 0, 0);
        set_row(1, -256, 512, 0, 0);
        set_row(2, 0, 0, 384, 0);
        set_row(3, 0, 64, 0, -640);
        run_case(1'b0);

        // tiny pivot: saturated reciprocal (R4)
        set_row(0, 1, 3, 0, 0);
        set_row(1, 0, 256, 0, 0);
        set_row(2, 0, 0, 256, 0);
        set_row(3, 0, 0, 0, 256);
        run_case(1'b0);

        // negative pivots (R4)
        set_row(0, -768, 256, 0, 0);
        set_row(1, 256, -1024, 128, 0);
        set_row(2, 0, 128, -640, 64);
        set_row(3, 0, 0, 32, -300);
        run_case(1'b0);

        // singular at step 0 (R9)
        set_row(0, 0, 256, 0, 0);
        set_row(1, 0, 0, 256, 0);
        set_row(2, 0, 0, 0, 256);
        set_row(3, 0, 128, 64, 32);
        run_case(1'b0);

        // clean run after singular clears the flag (R12)
        set_row(0, 512, 0, 0, 0);
        set_row(1, 0, 512, 0, 0);
        set_row(2, 0, 0, 512, 0);
        set_row(3, 0, 0, 0, 512);
        run_case(1'b0);

        // singular at step 1 (R9, R12)
        set_row(0, 256, 512, 0, 0);
        set_row(1, 256, 512, 256, 0);
        set_row(2, 0, 0, 256, 0);
        set_row(3, 0, 0, 0, 256);
        run_case(1'b0);

        // start and write while busy are ignored (R11)
        set_row(0, 0, 256, 512, 0);
        set_row(1, 768, 0, 256, 256);
        set_row(2, 256, 512, 0, 768);
        set_row(3, -512, 256, 256, 0);
        run_case(1'b1);

        // pseudo-random matrices
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) cur[i][j] = rnd();
            run_case(1'b0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule